// File: doc/BRIEF.md
# DDR SDRAM Bank State and Timing Monitor

This block sits passively on the command bus of a four-bank DDR SDRAM and decodes one command per rising clock edge from chip select, RAS, CAS, WE, the two bank select bits and the auto-precharge address bit. For each bank it keeps an open/closed flag. It also keeps saturating counters of the cycles since that bank's last activate, last precharge and last write, plus a counter of the cycles since the most recent activate to any bank.

Activates, precharges, reads and writes are checked against the bank state and against minimum spacing limits given as cycle-count parameters. When a command breaks a rule, the block raises a single-cycle error strobe with a 3-bit code, one clock after the command. Deselects and NOPs pass through without effect. The monitor never drives the memory. It is meant for simulation-time or in-silicon protocol checking next to a memory controller.

Top module: `bank_timing_monitor`

## Requirements
- R1: Commands are sampled when chipSelN is 0: rasN=0,casN=1,weN=1 is activate; rasN=0,casN=1,weN=0 is precharge; rasN=1,casN=0 is read (weN=1) or write (weN=0). bankSel value 0..3 selects bank 0..3.
- R2: With chipSelN=1 (deselect) every other control input is ignored, and with chipSelN=0 and rasN, casN, weN all 1 (NOP) nothing happens; neither changes bank state nor raises an error.
- R3: errValid is high for exactly the one cycle after the edge that sampled a faulty command, and errCode is valid while it is high. Codes: 1 activate to open bank, 2 read/write to closed bank, 3 activate-to-read/write spacing, 4 activate-to-activate spacing across banks, 5 precharge-to-activate spacing, 6 activate-to-activate spacing on one bank, 7 write-to-precharge spacing. If several rules fail at once, the lowest code is reported.
- R4: An activate to a bank that is already open gives code 1.
- R5: A read or write to a closed bank gives code 2.
- R6: A read or write fewer than T_RCD cycles after its bank's activate gives code 3. Exactly T_RCD cycles passes.
- R7: An activate fewer than T_RRD cycles after an activate to a different bank gives code 4. Exactly T_RRD cycles passes.
- R8: An activate fewer than T_RP cycles after its bank was precharged gives code 5.
- R9: An activate fewer than T_RC cycles after the previous activate of the same bank gives code 6.
- R10: A precharge reaching a bank fewer than T_WR cycles after a write to that bank gives code 7. Exactly T_WR cycles passes, and reads do not start this window.
- R11: A precharge with apBit=1 closes all four banks whatever bankSel holds. With apBit=0 it closes only the selected bank.
- R12: After reset all banks are closed and all counters are saturated, so the first commands pass. The counters saturate and never wrap, however long the bus stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipSelN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankSel | input | 2 | Bank select bits |
| apBit | input | 1 | All-banks flag for precharge (address bit 10) |
| errValid | output | 1 | One-cycle rule-violation strobe |
| errCode | output | 3 | Code of the violated rule |

## Verification
The bench builds the monitor with T_RCD=3, T_RRD=2, T_RP=3, T_RC=7 and T_WR=3. With these values every spacing window, and both its failing and its exactly-met edge, can be reached in a few cycles. Because the limit of 7 sets the counter width to three bits, a twenty-cycle idle stretch is enough to show that the counters saturate rather than wrap. The short T_RP together with the longer T_RC lets one activate break both limits at once, which tests the lowest-code priority, and a separate activate breaks T_RC alone.

// File: rtl/bank_mon_pkg.sv
package bank_mon_pkg;

  typedef struct packed {
    logic       act;
    logic       pre;
    logic       wr;
    logic       preAll;
    logic [1:0] bank;
  } cmdStrobe_t;

  localparam logic [2:0] ERR_NONE     = 3'd0;
  localparam logic [2:0] ERR_ACT_OPEN = 3'd1;
  localparam logic [2:0] ERR_COL_IDLE = 3'd2;
  localparam logic [2:0] ERR_RCD      = 3'd3;
  localparam logic [2:0] ERR_RRD      = 3'd4;
  localparam logic [2:0] ERR_RP       = 3'd5;
  localparam logic [2:0] ERR_RC       = 3'd6;
  localparam logic [2:0] ERR_WR       = 3'd7;

endpackage

// File: rtl/bank_mon_dpath.sv
module bank_mon_dpath
  import bank_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  cmdStrobe_t       cmd,
  output logic [NUM_BANKS-1:0] openVec,
  output logic [CNT_W-1:0] actCnt [NUM_BANKS],
  output logic [CNT_W-1:0] preCnt [NUM_BANKS],
  output logic [CNT_W-1:0] wrCnt  [NUM_BANKS],
  output logic [CNT_W-1:0] lastActCnt,
  output logic [1:0]       lastActBank
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit, actHit, preHit, wrHit;
    assign hit    = (cmd.bank == 2'(b));
    assign actHit = cmd.act && hit;
    assign preHit = cmd.pre && (cmd.preAll || hit);
    assign wrHit  = cmd.wr && hit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        openVec[b] <= 1'b0;
        actCnt[b]  <= CNT_MAX;
        preCnt[b]  <= CNT_MAX;
        wrCnt[b]   <= CNT_MAX;
      end else begin
        if (actHit)      openVec[b] <= 1'b1;
        else if (preHit) openVec[b] <= 1'b0;
        actCnt[b] <= actHit ? CNT_ONE : ((actCnt[b] == CNT_MAX) ? CNT_MAX : actCnt[b] + 1'b1);
        preCnt[b] <= preHit ? CNT_ONE : ((preCnt[b] == CNT_MAX) ? CNT_MAX : preCnt[b] + 1'b1);
        wrCnt[b]  <= wrHit  ? CNT_ONE : ((wrCnt[b]  == CNT_MAX) ? CNT_MAX : wrCnt[b]  + 1'b1);
      end
    end

    // R12
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
      (actCnt[b] == CNT_MAX && !actHit) |=> (actCnt[b] == CNT_MAX));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastActCnt  <= CNT_MAX;
      lastActBank <= 2'd0;
    end else if (cmd.act) begin
      lastActCnt  <= CNT_ONE;
      lastActBank <= cmd.bank;
    end else if (lastActCnt != CNT_MAX) begin
      lastActCnt  <= lastActCnt + 1'b1;
    end
  end

  // R11
  pre_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.pre && cmd.preAll) |=> (openVec == '0));

  // R2
  state_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.act || cmd.pre) |=> $stable(openVec));

endmodule

// File: rtl/bank_mon_ctrl.sv
module bank_mon_ctrl
  import bank_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 4,
  parameter int T_RCD     = 3,
  parameter int T_RRD     = 2,
  parameter int T_RP      = 3,
  parameter int T_RC      = 10,
  parameter int T_WR      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSelN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic [1:0]       bankSel,
  input  logic             apBit,
  input  logic [NUM_BANKS-1:0] openVec,
  input  logic [CNT_W-1:0] actCnt [NUM_BANKS],
  input  logic [CNT_W-1:0] preCnt [NUM_BANKS],
  input  logic [CNT_W-1:0] wrCnt  [NUM_BANKS],
  input  logic [CNT_W-1:0] lastActCnt,
  input  logic [1:0]       lastActBank,
  output cmdStrobe_t       cmd,
  output logic             errValid,
  output logic [2:0]       errCode
);

  localparam logic [CNT_W-1:0] RCD_L = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] RRD_L = CNT_W'(T_RRD);
  localparam logic [CNT_W-1:0] RP_L  = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] RC_L  = CNT_W'(T_RC);
  localparam logic [CNT_W-1:0] WR_L  = CNT_W'(T_WR);

  logic isAct, isPre, isRd, isWr, wrTooSoon;
  logic [2:0] codeNext;

  assign isAct = !chipSelN && !rasN &&  casN &&  weN;
  assign isPre = !chipSelN && !rasN &&  casN && !weN;
  assign isRd  = !chipSelN &&  rasN && !casN &&  weN;
  assign isWr  = !chipSelN &&  rasN && !casN && !weN;

  assign cmd.act    = isAct;
  assign cmd.pre    = isPre;
  assign cmd.wr     = isWr;
  assign cmd.preAll = apBit;
  assign cmd.bank   = bankSel;

  always_comb begin
    wrTooSoon = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if ((apBit || bankSel == 2'(i)) && wrCnt[i] < WR_L) wrTooSoon = 1'b1;
    end
  end

  always_comb begin
    codeNext = ERR_NONE;
    if (isAct) begin
      if (openVec[bankSel])                                  codeNext = ERR_ACT_OPEN;
      else if (lastActBank != bankSel && lastActCnt < RRD_L) codeNext = ERR_RRD;
      else if (preCnt[bankSel] < RP_L)                       codeNext = ERR_RP;
      else if (actCnt[bankSel] < RC_L)                       codeNext = ERR_RC;
    end else if (isRd || isWr) begin
      if (!openVec[bankSel])                                 codeNext = ERR_COL_IDLE;
      else if (actCnt[bankSel] < RCD_L)                      codeNext = ERR_RCD;
    end else if (isPre) begin
      if (wrTooSoon)                                         codeNext = ERR_WR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errValid <= 1'b0;
      errCode  <= ERR_NONE;
    end else begin
      errValid <= (codeNext != ERR_NONE);
      errCode  <= codeNext;
    end
  end

  // R4
  act_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isAct && openVec[bankSel]) |=> (errValid && errCode == ERR_ACT_OPEN));

  // R5
  col_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((isRd || isWr) && !openVec[bankSel]) |=> (errValid && errCode == ERR_COL_IDLE));

  // R3
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(isAct || isPre || isRd || isWr) |=> !errValid);

endmodule

// File: rtl/bank_timing_monitor.sv
module bank_timing_monitor
  import bank_mon_pkg::*;
#(
  parameter int T_RCD = 3,
  parameter int T_RRD = 2,
  parameter int T_RP  = 3,
  parameter int T_RC  = 10,
  parameter int T_WR  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chipSelN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  input  logic [1:0] bankSel,
  input  logic       apBit,
  output logic       errValid,
  output logic [2:0] errCode
);

  localparam int NUM_BANKS = 4;
  localparam int MAX_A = (T_RCD > T_RRD) ? T_RCD : T_RRD;
  localparam int MAX_B = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_T = (MAX_C > T_WR) ? MAX_C : T_WR;
  localparam int CNT_W = $clog2(MAX_T + 1);

  cmdStrobe_t cmd;
  logic [NUM_BANKS-1:0] openVec;
  logic [CNT_W-1:0] actCnt [NUM_BANKS];
  logic [CNT_W-1:0] preCnt [NUM_BANKS];
  logic [CNT_W-1:0] wrCnt  [NUM_BANKS];
  logic [CNT_W-1:0] lastActCnt;
  logic [1:0]       lastActBank;

  bank_mon_ctrl #(
    .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RRD(T_RRD),
    .T_RP(T_RP), .T_RC(T_RC), .T_WR(T_WR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankSel(bankSel), .apBit(apBit), .openVec(openVec),
    .actCnt(actCnt), .preCnt(preCnt), .wrCnt(wrCnt), .lastActCnt(lastActCnt),
    .lastActBank(lastActBank), .cmd(cmd), .errValid(errValid), .errCode(errCode)
  );

  bank_mon_dpath #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .openVec(openVec), .actCnt(actCnt),
    .preCnt(preCnt), .wrCnt(wrCnt), .lastActCnt(lastActCnt),
    .lastActBank(lastActBank)
  );

endmodule

// File: tb/bank_timing_monitor_bench.sv
`timescale 1ns/1ps
module bank_timing_monitor_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSelN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, apBit = 1'b0;
  logic [1:0] bankSel = 2'd0;
  logic errValid;
  logic [2:0] errCode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  bank_timing_monitor #(.T_RCD(3), .T_RRD(2), .T_RP(3), .T_RC(7), .T_WR(3)) u_bank_timing_monitor (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .rasN(rasN), .casN(casN),
    .weN(weN), .bankSel(bankSel), .apBit(apBit), .errValid(errValid), .errCode(errCode)
  );

  // monitor: compares the result of the command sampled at this edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      int e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (errValid !== (e != 0) || (e != 0 && errCode !== 3'(e))) begin
        errors++;
        $display("FAIL %s: errValid=%0b errCode=%0d expected valid=%0b code=%0d",
                 t, errValid, errCode, (e != 0), e);
      end
    end
  end

  task automatic drive(input logic cs, input logic ras, input logic cas, input logic we,
                       input logic [1:0] ba, input logic ap, input int exp, input string tag);
    @(negedge clk);
    chipSelN = cs; rasN = ras; casN = cas; weN = we; bankSel = ba; apBit = ap;
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  task automatic act(input logic [1:0] b, input int exp, input string tag);
    drive(1'b0, 1'b0, 1'b1, 1'b1, b, 1'b0, exp, tag);
  endtask
  task automatic pre(input logic [1:0] b, input logic ap, input int exp, input string tag);
    drive(1'b0, 1'b0, 1'b1, 1'b0, b, ap, exp, tag);
  endtask
  task automatic rd(input logic [1:0] b, input int exp, input string tag);
    drive(1'b0, 1'b1, 1'b0, 1'b1, b, 1'b0, exp, tag);
  endtask
  task automatic wr(input logic [1:0] b, input int exp, input string tag);
    drive(1'b0, 1'b1, 1'b0, 1'b0, b, 1'b0, exp, tag);
  endtask
  task automatic nop(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 0, "R2 nop");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (errValid !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset: errValid=%0b expected 0", errValid);
    end
    act(2'd0, 0, "R12 first activate after reset");
    act(2'd1, 4, "R7 activate other bank too soon");
    rd(2'd0, 3, "R6 read before T_RCD");
    wr(2'd0, 0, "R6 write exactly at T_RCD");
    pre(2'd0, 1'b0, 7, "R10 precharge after write too soon");
    rd(2'd0, 2, "R5 read to closed bank");
    act(2'd0, 5, "R3 R8 precharge spacing beats R9");
    act(2'd0, 1, "R4 activate open bank");
    drive(1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 0, "R2 deselect ignored");
    pre(2'd3, 1'b1, 0, "R11 precharge all");
    rd(2'd1, 2, "R11 bank 1 closed by precharge all");
    nop(1);
    act(2'd2, 0, "R1 activate bank 2");
    nop(2);
    wr(2'd2, 0, "R1 write bank 2");
    nop(2);
    pre(2'd2, 1'b0, 0, "R10 precharge exactly at T_WR");
    act(2'd3, 0, "R1 activate bank 3");
    nop(1);
    act(2'd1, 0, "R7 activate exactly at T_RRD");
    pre(2'd1, 1'b0, 0, "R1 precharge bank 1");
    act(2'd1, 5, "R8 activate right after precharge");
    pre(2'd3, 1'b0, 0, "R11 single precharge bank 3");
    rd(2'd3, 2, "R11 bank 3 closed");
    rd(2'd1, 0, "R11 bank 1 still open");
    pre(2'd1, 1'b0, 0, "R10 read starts no write window");
    nop(20);
    act(2'd1, 0, "R12 counters saturate without wrap");
    nop(1);
    act(2'd2, 0, "R1 activate bank 2 again");
    pre(2'd2, 1'b0, 0, "R1 precharge bank 2");
    nop(2);
    act(2'd2, 6, "R9 activate before T_RC");
    pre(2'd0, 1'b1, 0, "R11 final precharge all");
    nop(3);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule